// File: doc/BRIEF.md
# Hammer Strike Column Capture Buffer

This block sits between a rotating print drum model and a line-oriented print path. Each print column has a hammer-fire input that stays asserted for a very long time compared with the system clock, typically around 100,000 cycles. The block records which drum sector code was under the hammer when that column fired. It holds one small memory slot per column instead of a register bank. A free-running scanner visits one hammer input per clock. Whenever the visited hammer is active, the scanner writes the current sector code into that column's slot. A hammer held for a whole strike is therefore written many times with the same value, and that does no harm.

There are eighteen columns. Seventeen carry characters and the last one selects black or red ink. A column that was never struck holds the blank code 15, which is outside the sector range 0 to 12. When the paper-feed input pulses, the block stops capturing and walks the slots in ascending column order, with the ink column last. It pushes each code, untranslated, into a downstream FIFO write port. It stalls while that FIFO is full and writes the blank code back into each slot as that slot is read. A one-cycle done pulse follows the final write. After reset, a clearing sweep fills every slot with the blank code before capture begins.

Top module: `strike_column_buffer`

## Requirements
- R1: While reset is held, `fifo_wr_o` and `done_o` are low. Reset is followed by a sweep of NUM_COLS cycles that writes the blank code 15 into every slot. A readout after that sweep with no strikes emits 15 for every column.
- R2: The scanner visits column indices 0, 1, ..., NUM_COLS-1 on successive clocks and then wraps to 0. It runs continuously, so a hammer held for at least NUM_COLS cycles while the sector input is steady is captured.
- R3: A captured slot holds the 4-bit value on `sector_i` as it was when that column was scanned, with no translation. Repeated captures of the same code leave the slot unchanged.
- R4: A column with no strike since the last readout (or since reset) is emitted as the blank code 15.
- R5: A `feed_i` high at a clock edge while idle starts a readout, and the first FIFO write can occur in the next cycle. The readout produces exactly NUM_COLS writes, for column indices 0 to NUM_COLS-1 in ascending order. Column NUM_COLS-1, the ink column, is last.
- R6: While `fifo_full_i` is high, `fifo_wr_o` stays low and the readout holds at its current column. That column's code is written once the full flag drops.
- R7: `done_o` is high for exactly one cycle, the cycle right after the final FIFO write of a readout.
- R8: Every slot holds the blank code after a readout, so a second readout with no strikes in between emits 15 for every column.
- R9: Hammer inputs are ignored while a readout is in progress. A hammer that is active only during a readout leaves its slot blank.
- R10: `feed_i` is ignored while a readout is in progress. No extra FIFO writes follow the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hammer_i | input | NUM_COLS | Hammer-fire strobes, one per column; the top bit is the ink column |
| sector_i | input | CODE_W | Drum sector code currently under the hammers (0 to 12) |
| feed_i | input | 1 | Paper-feed request; starts a readout when idle |
| fifo_full_i | input | 1 | Downstream FIFO full flag |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | CODE_W | Column code presented with the write strobe |
| done_o | output | 1 | One-cycle pulse after the last column is written |

## Verification
The bench attacks the ends of the column range: column 0 and the ink column, and sector codes 0 and 12. A scanner that skips or wraps early, or a readout that is off by one, would drop or shift these columns. Long and random stalls from the FIFO full flag test the stall behaviour. A design that advances or writes while the FIFO is full would lose or repeat a column. Hammers pulsed only inside a readout, and a feed request held high throughout one, check that capture is locked out and that no second readout starts. A design that gets this wrong would show a stray code in the next line or push extra words after the done pulse. Back-to-back readouts with no strikes in between show whether slots are cleared to the blank code after readout.

// File: rtl/strike_pkg.sv
package strike_pkg;

   // default geometry: seventeen character columns plus one ink column
   localparam int unsigned STRIKE_COLS_DEF  = 18;
   localparam int unsigned STRIKE_CODE_DEF  = 4;
   localparam int unsigned STRIKE_SECT_MAX  = 12;
   localparam int unsigned STRIKE_BLANK_DEF = 15;

   typedef enum logic [1:0] {
      SEQ_CLEAR = 2'd0,
      SEQ_IDLE  = 2'd1,
      SEQ_READ  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/strike_scan.sv
module strike_scan #(
   parameter int unsigned NUM_COLS = strike_pkg::STRIKE_COLS_DEF,
   parameter int unsigned IDX_W    = $clog2(NUM_COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [IDX_W-1:0] scan_idx_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COLS - 1);

   logic [IDX_W-1:0] idx_q;

   generate
      if ((64'd1 << IDX_W) == 64'(NUM_COLS)) begin : g_pow2_wrap
         // column count fills the index range: natural rollover
         always_ff @(posedge clk) begin
            if (!rst_n) idx_q <= '0;
            else        idx_q <= idx_q + 1'b1;
         end
      end else begin : g_cmp_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)                idx_q <= '0;
            else if (idx_q == LAST_IDX) idx_q <= '0;
            else                       idx_q <= idx_q + 1'b1;
         end
      end
   endgenerate

   assign scan_idx_o = idx_q;

endmodule

// File: rtl/strike_slot_mem.sv
module strike_slot_mem #(
   parameter int unsigned DEPTH  = strike_pkg::STRIKE_COLS_DEF,
   parameter int unsigned DATA_W = strike_pkg::STRIKE_CODE_DEF,
   parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   // single address, one write per clock, asynchronous read
   logic [DATA_W-1:0] slot_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) slot_q[addr_i] <= wdata_i;
   end

   assign rdata_o = slot_q[addr_i];

endmodule

// File: rtl/strike_readout_seq.sv
module strike_readout_seq
   import strike_pkg::*;
#(
   parameter int unsigned NUM_COLS = STRIKE_COLS_DEF,
   parameter int unsigned IDX_W    = $clog2(NUM_COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             feed_i,
   input  logic             fifo_full_i,
   output logic [IDX_W-1:0] rd_idx_o,
   output logic             busy_o,
   output logic             reading_o,
   output logic             clr_we_o,
   output logic             fifo_wr_o,
   output logic             done_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COLS - 1);

   seq_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             done_q;

   always_comb begin
      reading_o = (state_q == SEQ_READ);
      clr_we_o  = (state_q == SEQ_CLEAR);
      busy_o    = (state_q != SEQ_IDLE);
      fifo_wr_o = reading_o && !fifo_full_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_CLEAR;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SEQ_CLEAR: begin
               if (idx_q == LAST_IDX) begin
                  state_q <= SEQ_IDLE;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            SEQ_IDLE: begin
               if (feed_i) begin
                  state_q <= SEQ_READ;
                  idx_q   <= '0;
               end
            end
            SEQ_READ: begin
               if (!fifo_full_i) begin
                  if (idx_q == LAST_IDX) begin
                     state_q <= SEQ_IDLE;
                     idx_q   <= '0;
                     done_q  <= 1'b1;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            default: begin
               state_q <= SEQ_CLEAR;
               idx_q   <= '0;
            end
         endcase
      end
   end

   assign rd_idx_o = idx_q;
   assign done_o   = done_q;

endmodule

// File: rtl/strike_column_buffer.sv
module strike_column_buffer
   import strike_pkg::*;
#(
   parameter int unsigned NUM_COLS   = STRIKE_COLS_DEF,
   parameter int unsigned CODE_W     = STRIKE_CODE_DEF,
   parameter int unsigned SECTOR_MAX = STRIKE_SECT_MAX,
   parameter int unsigned BLANK_CODE = STRIKE_BLANK_DEF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_COLS-1:0] hammer_i,
   input  logic [CODE_W-1:0]   sector_i,
   input  logic                feed_i,
   input  logic                fifo_full_i,
   output logic                fifo_wr_o,
   output logic [CODE_W-1:0]   fifo_data_o,
   output logic                done_o
);

   localparam int unsigned IDX_W = $clog2(NUM_COLS);
   localparam logic [CODE_W-1:0] BLANK_VAL = CODE_W'(BLANK_CODE);

   generate
      if (NUM_COLS < 2) begin : g_bad_cols
         $error("strike_column_buffer: NUM_COLS must be at least 2");
      end
      if (BLANK_CODE <= SECTOR_MAX) begin : g_bad_blank
         $error("strike_column_buffer: BLANK_CODE must lie above SECTOR_MAX");
      end
      if (BLANK_CODE >= (64'd1 << CODE_W)) begin : g_bad_width
         $error("strike_column_buffer: BLANK_CODE does not fit in CODE_W");
      end
   endgenerate

   logic [IDX_W-1:0]  scan_idx;
   logic [IDX_W-1:0]  rd_idx;
   logic              busy;
   logic              reading;
   logic              clr_we;
   logic              cap_we;
   logic              mem_we;
   logic [IDX_W-1:0]  mem_addr;
   logic [CODE_W-1:0] mem_wdata;
   logic [CODE_W-1:0] mem_rdata;

   strike_scan #(
      .NUM_COLS (NUM_COLS),
      .IDX_W    (IDX_W)
   ) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_idx_o (scan_idx)
   );

   strike_readout_seq #(
      .NUM_COLS (NUM_COLS),
      .IDX_W    (IDX_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .feed_i      (feed_i),
      .fifo_full_i (fifo_full_i),
      .rd_idx_o    (rd_idx),
      .busy_o      (busy),
      .reading_o   (reading),
      .clr_we_o    (clr_we),
      .fifo_wr_o   (fifo_wr_o),
      .done_o      (done_o)
   );

   // capture path owns the memory only while the sequencer is idle
   always_comb begin
      cap_we = !busy && hammer_i[scan_idx];
      if (busy) begin
         mem_addr  = rd_idx;
         mem_we    = clr_we || fifo_wr_o;
         mem_wdata = BLANK_VAL;
      end else begin
         mem_addr  = scan_idx;
         mem_we    = cap_we;
         mem_wdata = sector_i;
      end
   end

   strike_slot_mem #(
      .DEPTH  (NUM_COLS),
      .DATA_W (CODE_W),
      .ADDR_W (IDX_W)
   ) u_mem (
      .clk     (clk),
      .we_i    (mem_we),
      .addr_i  (mem_addr),
      .wdata_i (mem_wdata),
      .rdata_o (mem_rdata)
   );

   assign fifo_data_o = mem_rdata;

endmodule

// File: rtl/strike_chk.sv
module strike_chk #(
   parameter int unsigned NUM_COLS = 18,
   parameter int unsigned IDX_W    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_full_i,
   input logic             fifo_wr_o,
   input logic             done_o,
   input logic [IDX_W-1:0] scan_idx,
   input logic [IDX_W-1:0] rd_idx,
   input logic             busy,
   input logic             reading,
   input logic             cap_we
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COLS - 1);

   // R2
   scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> scan_idx == (($past(scan_idx) == LAST_IDX) ? '0 : IDX_W'($past(scan_idx) + 1'b1)));

   // R5
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr_o && rd_idx != LAST_IDX) |=> rd_idx == IDX_W'($past(rd_idx) + 1'b1));

   // R6
   no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full_i |-> !fifo_wr_o);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reading && fifo_full_i) |=> (reading && $stable(rd_idx)));

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(fifo_wr_o) && $past(rd_idx) == LAST_IDX));

   // R9
   no_capture_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cap_we);

endmodule

bind strike_column_buffer strike_chk #(
   .NUM_COLS (NUM_COLS),
   .IDX_W    (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fifo_full_i (fifo_full_i),
   .fifo_wr_o   (fifo_wr_o),
   .done_o      (done_o),
   .scan_idx    (scan_idx),
   .rd_idx      (rd_idx),
   .busy        (busy),
   .reading     (reading),
   .cap_we      (cap_we)
);

// File: tb/sim_strike_column_buffer.sv
`timescale 1ns/1ps
module sim_strike_column_buffer;

   localparam int NC    = 18;
   localparam int CW    = 4;
   localparam int BLANK = 15;
   localparam int SMAX  = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] hammer = '0;
   logic [CW-1:0] sector = '0;
   logic          feed = 1'b0;
   logic          full = 1'b0;
   logic          wr;
   logic [CW-1:0] data;
   logic          done;

   int total = 0;
   int bad   = 0;
   int exp_code [NC];

   always #4 clk = ~clk;

   strike_column_buffer u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .hammer_i    (hammer),
      .sector_i    (sector),
      .feed_i      (feed),
      .fifo_full_i (full),
      .fifo_wr_o   (wr),
      .fifo_data_o (data),
      .done_o      (done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   function automatic int pick_code();
      int r = int'($urandom % 3);
      if (r == 0) return BLANK;
      return int'($urandom % (SMAX + 1));
   endfunction

   function automatic bit stall_at(input int mode, input int cyc);
      if (mode == 1) return ($urandom % 3) == 0;
      if (mode == 2) return (cyc < 10) || (cyc == 15) || (cyc == 16);
      return 1'b0;
   endfunction

   // R2 R3: drive every sector in turn, hold the matching hammers a full scan+
   task automatic strike_all();
      for (int s = 0; s <= SMAX; s++) begin
         logic [NC-1:0] m = '0;
         for (int c = 0; c < NC; c++) if (exp_code[c] == s) m[c] = 1'b1;
         if (m != '0) begin
            @(negedge clk);
            sector = CW'(s);
            hammer = m;
            repeat (NC + 2) @(negedge clk);
            hammer = '0;
         end
      end
      @(negedge clk);
   endtask

   task automatic readout(input int mode, input logic [NC-1:0] inj, input bit hold_feed);
      int nwr = 0;
      int last_wr = -1;
      int done_cyc = -1;
      int cyc = 0;
      @(negedge clk);
      full = 1'b0;
      feed = 1'b1;
      @(negedge clk);
      feed   = hold_feed;
      hammer = inj;
      sector = CW'(5);
      while (cyc < 400 && done_cyc < 0) begin
         full = stall_at(mode, cyc);
         #1;
         if (full) check(wr == 1'b0, "R6", "write while full", int'(wr), 0);
         if (wr) begin
            if (nwr < NC) begin
               check(int'(data) == exp_code[nwr],
                     (exp_code[nwr] == BLANK) ? "R4" : "R3",
                     $sformatf("code of column %0d", nwr), int'(data), exp_code[nwr]);
            end
            nwr++;
            last_wr = cyc;
            if (nwr == NC) begin
               feed   = 1'b0;
               hammer = '0;
            end
         end
         if (done) done_cyc = cyc;
         @(negedge clk);
         cyc++;
      end
      feed = 1'b0;
      hammer = '0;
      full = 1'b0;
      check(nwr == NC, "R5", "write count", nwr, NC);
      check(done_cyc == last_wr + 1, "R7", "done cycle", done_cyc, last_wr + 1);
      for (int k = 0; k < 4; k++) begin
         #1;
         if (k == 0) check(done == 1'b0, "R7", "done width", int'(done), 0);
         check(wr == 1'b0, "R10", "write after done", int'(wr), 0);
         @(negedge clk);
      end
      for (int c = 0; c < NC; c++) exp_code[c] = BLANK;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0417));
      for (int c = 0; c < NC; c++) exp_code[c] = BLANK;

      // R1: outputs quiet under reset
      repeat (3) @(negedge clk);
      #1;
      check(wr == 1'b0, "R1", "wr in reset", int'(wr), 0);
      check(done == 1'b0, "R1", "done in reset", int'(done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (NC + 4) @(negedge clk);

      // R1: slots blank after the clearing sweep
      readout(0, '0, 1'b0);

      // R2 R3: edge columns and edge codes, long stall (R6)
      exp_code[0]      = 0;
      exp_code[9]      = 7;
      exp_code[NC - 1] = SMAX;
      strike_all();
      readout(2, '0, 1'b0);

      // R8: second readout with no strikes is all blank
      readout(1, '0, 1'b0);

      // R9: hammers active only during readout; R10: feed held through it
      exp_code[3] = 4;
      strike_all();
      readout(0, 18'h2_a5a5, 1'b1);
      readout(0, '0, 1'b0);

      // random mix
      for (int t = 0; t < 8; t++) begin
         for (int c = 0; c < NC; c++) exp_code[c] = pick_code();
         strike_all();
         readout(t % 3, (t == 5) ? NC'($urandom) : '0, (t % 2) == 1);
      end

      finish_run();
   end

endmodule